// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This unit sits in the execute stage of a 32-bit RISC pipeline. It decodes one instruction word per cycle and decides whether it is a conditional branch or a conditional trap. When it is, the unit evaluates the comparison that the instruction names. The comparison can be one of three kinds:

- the first source register against the second;
- the first source register against zero;
- the first source register against a 16-bit immediate, sign-extended.

Each comparison is done in signed or unsigned form, as the encoding requires. The unit does not compute branch targets, annul delay slots or vector exceptions. It only reports what the downstream logic must do.

The result leaves through one register stage. In the cycle after an instruction and its operands are presented, the unit drives five flags:

- branch taken;
- trap raised;
- link requested, for the and-link branch forms;
- likely, for the forms that annul the delay slot when the branch is not taken;
- illegal, for every encoding outside the recognised set.

Top module: `bte_cond_eval`

## Requirements
- R1: While rst_ni is low, all five outputs are 0, and they go to 0 as soon as reset is asserted.
- R2: The outputs reflect the instruction and operands that were sampled at the previous rising clock edge (latency of one cycle).
- R3: Primary opcode (bits 31:26) 0x04 takes the branch when rs equals rt, and 0x05 takes it when they differ. Opcode 0x06 takes it when rs is signed at most zero, and 0x07 when rs is signed greater than zero. For all four, likely_o is 0.
- R4: Primary opcodes 0x14 to 0x17 use the same conditions as 0x04 to 0x07, and likely_o is 1 whether or not the branch is taken.
- R5: With primary opcode 0x01, the selector in bits 20:16 works as follows. 0x00 branches when rs is signed negative and 0x01 branches when rs is signed at least zero. 0x02 and 0x03 are the same two branches with likely_o at 1.
- R6: Selectors 0x10 to 0x13 under opcode 0x01 repeat the conditions of 0x00 to 0x03, and set link_o to 1 whether or not the branch is taken.
- R7: Selectors 0x08 to 0x0C and 0x0E under opcode 0x01 raise trap_o when rs compares against bits 15:0, sign-extended to 32 bits, as follows:

  | Selector | Trap condition | Compare |
  |---|---|---|
  | 0x08 | rs greater or equal | signed |
  | 0x09 | rs greater or equal | unsigned |
  | 0x0A | rs less than | signed |
  | 0x0B | rs less than | unsigned |
  | 0x0C | rs equal | — |
  | 0x0E | rs not equal | — |

  The unsigned forms also use the sign-extended value.
- R8: With primary opcode 0x00, function codes (bits 5:0) 0x30 to 0x34 and 0x36 raise trap_o when rs compares against rt. The comparisons are greater-or-equal signed, greater-or-equal unsigned, less-than signed, less-than unsigned, equal and not-equal, in that code order.
- R9: Every other encoding sets illegal_o to 1, with taken_o, trap_o, link_o and likely_o all 0. Examples are opcode 0x01 with selector 0x0D, and opcode 0x00 with function 0x35.
- R10: taken_o and trap_o are never both 1. A trap form never sets taken_o, link_o or likely_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | XLEN | Value of the first source register |
| rt_val_i | input | XLEN | Value of the second source register |
| taken_o | output | 1 | Branch condition holds |
| trap_o | output | 1 | Trap condition holds |
| link_o | output | 1 | And-link form decoded |
| likely_o | output | 1 | Annul-on-not-taken form decoded |
| illegal_o | output | 1 | Encoding not recognised |

## Verification
Directed vectors first pit equal against unequal register pairs. They then drive rs at -1, 0 and 1 into the zero forms, which separates the strict comparisons from the inclusive ones. Next, the value 0x80000000 is compared with 1 in both signedness forms; this exposes any signed/unsigned swap. Immediate traps use rs = 5 against immediate 0xFFFF, so the signed form sees -1 and the unsigned form sees 0xFFFFFFFF; this shows whether the immediate is sign-extended. A long run then mixes random encodings, weighted toward the gaps in each selector range, with corner-biased operands, and compares against a behavioural model.

// File: rtl/bte_pkg.sv
package bte_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int SEL_W   = 5;
  localparam int FN_W    = 6;

  typedef enum logic [3:0] {
    CK_EQ, CK_NE, CK_LEZ, CK_GTZ, CK_LTZ, CK_GEZ,
    CK_GES, CK_GEU, CK_LTS, CK_LTU
  } cmp_kind_e;

  typedef struct packed {
    logic      br;
    logic      trp;
    logic      link;
    logic      likely;
    logic      illegal;
    logic      use_imm;
    cmp_kind_e kind;
  } dec_t;

  // low three bits of a trap code pick the comparison
  function automatic cmp_kind_e trap_kind(input logic [2:0] k);
    case (k)
      3'd0:    trap_kind = CK_GES;
      3'd1:    trap_kind = CK_GEU;
      3'd2:    trap_kind = CK_LTS;
      3'd3:    trap_kind = CK_LTU;
      3'd4:    trap_kind = CK_EQ;
      default: trap_kind = CK_NE;
    endcase
  endfunction
endpackage

// File: rtl/bte_decode.sv
module bte_decode
  import bte_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [FN_W-1:0]  fn_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o         = '0;
    dec_o.kind    = CK_EQ;
    dec_o.illegal = 1'b1;
    case (opc_i)
      6'h00: begin
        if (fn_i[5:3] == 3'b110 && fn_i[2:0] != 3'd5 && fn_i[2:0] != 3'd7) begin
          dec_o.trp     = 1'b1;
          dec_o.illegal = 1'b0;
          dec_o.kind    = trap_kind(fn_i[2:0]);
        end
      end
      6'h01: begin
        case (sel_i)
          5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h11, 5'h12, 5'h13: begin
            dec_o.br      = 1'b1;
            dec_o.illegal = 1'b0;
            dec_o.likely  = sel_i[1];
            dec_o.link    = sel_i[4];
            dec_o.kind    = sel_i[0] ? CK_GEZ : CK_LTZ;
          end
          5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0E: begin
            dec_o.trp     = 1'b1;
            dec_o.illegal = 1'b0;
            dec_o.use_imm = 1'b1;
            dec_o.kind    = trap_kind(sel_i[2:0]);
          end
          default: ;
        endcase
      end
      6'h04, 6'h05, 6'h06, 6'h07, 6'h14, 6'h15, 6'h16, 6'h17: begin
        dec_o.br      = 1'b1;
        dec_o.illegal = 1'b0;
        dec_o.likely  = opc_i[4];
        case (opc_i[1:0])
          2'd0:    dec_o.kind = CK_EQ;
          2'd1:    dec_o.kind = CK_NE;
          2'd2:    dec_o.kind = CK_LEZ;
          default: dec_o.kind = CK_GTZ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bte_compare.sv
module bte_compare
  import bte_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  cmp_kind_e       kind_i,
  output logic            cond_o
);
  localparam int MSB = XLEN - 1;

  logic eq, lt_s, lt_u, a_neg, a_zero;

  assign eq     = (a_i == b_i);
  assign lt_u   = (a_i < b_i);
  assign lt_s   = ($signed(a_i) < $signed(b_i));
  assign a_neg  = a_i[MSB];
  assign a_zero = (a_i == '0);

  always_comb begin
    case (kind_i)
      CK_EQ:   cond_o = eq;
      CK_NE:   cond_o = !eq;
      CK_LEZ:  cond_o = a_neg || a_zero;
      CK_GTZ:  cond_o = !a_neg && !a_zero;
      CK_LTZ:  cond_o = a_neg;
      CK_GEZ:  cond_o = !a_neg;
      CK_GES:  cond_o = !lt_s;
      CK_GEU:  cond_o = !lt_u;
      CK_LTS:  cond_o = lt_s;
      CK_LTU:  cond_o = lt_u;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bte_cond_eval.sv
module bte_cond_eval
  import bte_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    rs_val_i,
  input  logic [XLEN-1:0]    rt_val_i,
  output logic               taken_o,
  output logic               trap_o,
  output logic               link_o,
  output logic               likely_o,
  output logic               illegal_o
);
  localparam int EXT_W = XLEN - IMM_W;

  dec_t            dec;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] opnd_b;
  logic            cond;
  logic            unused_rs_fld;

  assign unused_rs_fld = ^instr_i[25:21];

  bte_decode u_decode (
    .opc_i (instr_i[31:26]),
    .sel_i (instr_i[20:16]),
    .fn_i  (instr_i[5:0]),
    .dec_o (dec)
  );

  // immediate always sign-extended, also for unsigned compares
  assign imm_sx = {{EXT_W{instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
  assign opnd_b = dec.use_imm ? imm_sx : rt_val_i;

  bte_compare #(.XLEN(XLEN)) u_compare (
    .a_i    (rs_val_i),
    .b_i    (opnd_b),
    .kind_i (dec.kind),
    .cond_o (cond)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      trap_o    <= 1'b0;
      link_o    <= 1'b0;
      likely_o  <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      taken_o   <= dec.br && cond;
      trap_o    <= dec.trp && cond;
      link_o    <= dec.link;
      likely_o  <= dec.likely;
      illegal_o <= dec.illegal;
    end
  end

  // R10
  taken_trap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(taken_o && trap_o));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(taken_o || trap_o || link_o || likely_o));

  // R3
  beq_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[31:26] == 6'h04 && rs_val_i == rt_val_i) |=> taken_o);

  // R6
  link_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[31:26] == 6'h01 && instr_i[20:18] == 3'b100) |=> (link_o && !trap_o));
endmodule

// File: tb/bte_cond_eval_bench.sv
`timescale 1ns/1ps
module bte_cond_eval_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic        taken, trap, link, likely, illegal;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  bte_cond_eval u_bte_cond_eval (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .instr_i   (instr),
    .rs_val_i  (rs_val),
    .rt_val_i  (rt_val),
    .taken_o   (taken),
    .trap_o    (trap),
    .link_o    (link),
    .likely_o  (likely),
    .illegal_o (illegal)
  );

  // behavioural reference: {taken, trap, link, likely, illegal}
  function automatic logic [4:0] ref_eval(input logic [31:0] ins, input logic [31:0] rs,
                                          input logic [31:0] rt);
    int     op  = int'(ins[31:26]);
    int     sel = int'(ins[20:16]);
    int     fn  = int'(ins[5:0]);
    longint sa  = longint'($signed(rs));
    longint sb  = longint'($signed(rt));
    longint ua  = longint'({32'b0, rs});
    longint ub  = longint'({32'b0, rt});
    logic [31:0] ix = {{16{ins[15]}}, ins[15:0]};
    longint si  = longint'($signed(ix));
    longint ui  = longint'({32'b0, ix});
    bit br = 0, tr = 0, lk = 0, lh = 0, il = 0, c = 0;
    if (op inside {4, 5, 6, 7, 20, 21, 22, 23}) begin
      br = 1;
      lh = (op >= 20);
      case (op % 4)
        0: c = (sa == sb);
        1: c = (sa != sb);
        2: c = (sa <= 0);
        default: c = (sa > 0);
      endcase
    end else if (op == 1) begin
      if (sel inside {0, 1, 2, 3, 16, 17, 18, 19}) begin
        br = 1;
        lk = (sel >= 16);
        lh = ((sel % 4) >= 2);
        c  = (sel % 2 == 1) ? (sa >= 0) : (sa < 0);
      end else if (sel inside {8, 9, 10, 11, 12, 14}) begin
        tr = 1;
        case (sel)
          8:  c = (sa >= si);
          9:  c = (ua >= ui);
          10: c = (sa < si);
          11: c = (ua < ui);
          12: c = (sa == si);
          default: c = (sa != si);
        endcase
      end else il = 1;
    end else if (op == 0 && fn inside {48, 49, 50, 51, 52, 54}) begin
      tr = 1;
      case (fn)
        48: c = (sa >= sb);
        49: c = (ua >= ub);
        50: c = (sa < sb);
        51: c = (ua < ub);
        52: c = (sa == sb);
        default: c = (sa != sb);
      endcase
    end else il = 1;
    return {br & c, tr & c, lk, lh, il};
  endfunction

  function automatic logic [31:0] mk_br(input logic [5:0] op);
    return {op, 26'd0};
  endfunction
  function automatic logic [31:0] mk_ri(input logic [4:0] sel, input logic [15:0] imm);
    return {6'h01, 5'd0, sel, imm};
  endfunction
  function automatic logic [31:0] mk_sp(input logic [5:0] fn);
    return {6'h00, 20'd0, fn};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] got = {taken, trap, link, likely, illegal};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s instr=%h rs=%h rt=%h got=%b exp=%b", req, instr, rs_val, rt_val, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] rs, input logic [31:0] rt,
                       input string req);
    logic [4:0] exp;
    @(negedge clk);
    instr = ins; rs_val = rs; rt_val = rt;
    exp = ref_eval(ins, rs, rt);
    @(negedge clk);
    check(req, exp);
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: held in reset with a taking branch on the inputs
    instr = mk_br(6'h04); rs_val = 32'd3; rt_val = 32'd3;
    repeat (3) @(negedge clk);
    check("R1 reset", 5'b0);
    rst_ni = 1'b1;

    // R3
    apply(mk_br(6'h04), 32'd7, 32'd7, "R3 beq equal");
    apply(mk_br(6'h04), 32'd7, 32'd8, "R3 beq unequal");
    apply(mk_br(6'h05), 32'd7, 32'd8, "R3 bne");
    apply(mk_br(6'h06), 32'd0, 32'd0, "R3 lez zero");
    apply(mk_br(6'h06), 32'hFFFF_FFFF, 32'd0, "R3 lez neg");
    apply(mk_br(6'h06), 32'd1, 32'd0, "R3 lez pos");
    apply(mk_br(6'h07), 32'd0, 32'd0, "R3 gtz zero");
    apply(mk_br(6'h07), 32'd1, 32'd0, "R3 gtz pos");
    // R4
    apply(mk_br(6'h14), 32'd2, 32'd2, "R4 likely eq");
    apply(mk_br(6'h17), 32'h8000_0000, 32'd0, "R4 likely gtz not taken");
    // R5
    apply(mk_ri(5'h00, 16'h0), 32'hFFFF_FFFF, 32'd0, "R5 ltz");
    apply(mk_ri(5'h00, 16'h0), 32'd0, 32'd0, "R5 ltz zero");
    apply(mk_ri(5'h01, 16'h0), 32'd0, 32'd0, "R5 gez zero");
    apply(mk_ri(5'h03, 16'h0), 32'hFFFF_FFFF, 32'd0, "R5 gez likely");
    // R6
    apply(mk_ri(5'h10, 16'h0), 32'd5, 32'd0, "R6 link not taken");
    apply(mk_ri(5'h11, 16'h0), 32'd5, 32'd0, "R6 link taken");
    apply(mk_ri(5'h12, 16'h0), 32'h8000_0000, 32'd0, "R6 link likely");
    // R7
    apply(mk_ri(5'h08, 16'hFFFF), 32'd5, 32'd0, "R7 ge signed imm");
    apply(mk_ri(5'h09, 16'hFFFF), 32'd5, 32'd0, "R7 ge unsigned imm sext");
    apply(mk_ri(5'h0B, 16'hFFFF), 32'd5, 32'd0, "R7 lt unsigned imm sext");
    apply(mk_ri(5'h0A, 16'hFFFF), 32'd5, 32'd0, "R7 lt signed imm");
    apply(mk_ri(5'h0C, 16'h8000), 32'hFFFF_8000, 32'd0, "R7 eq imm");
    apply(mk_ri(5'h0E, 16'h8000), 32'hFFFF_8000, 32'd0, "R7 ne imm");
    // R8
    apply(mk_sp(6'h30), 32'h8000_0000, 32'd1, "R8 ge signed");
    apply(mk_sp(6'h31), 32'h8000_0000, 32'd1, "R8 ge unsigned");
    apply(mk_sp(6'h32), 32'h8000_0000, 32'd1, "R8 lt signed");
    apply(mk_sp(6'h33), 32'h8000_0000, 32'd1, "R8 lt unsigned");
    apply(mk_sp(6'h34), 32'd9, 32'd9, "R8 eq");
    apply(mk_sp(6'h36), 32'd9, 32'd9, "R8 ne");
    // R9
    apply(mk_ri(5'h0D, 16'h0), 32'd0, 32'd0, "R9 regimm gap");
    apply(mk_ri(5'h04, 16'h0), 32'd0, 32'd0, "R9 regimm 04");
    apply(mk_sp(6'h35), 32'd1, 32'd1, "R9 special gap");
    apply(mk_sp(6'h20), 32'd1, 32'd1, "R9 special other");
    apply(mk_br(6'h02), 32'd1, 32'd1, "R9 opcode 02");
    // R10: trap form with branch-like operands
    apply(mk_sp(6'h34), 32'd0, 32'd0, "R10 trap no taken");

    // R1: asynchronous reset mid-run
    apply(mk_ri(5'h11, 16'h0), 32'd1, 32'd0, "R1 pre-reset");
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", 5'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: mixed random traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins, a, b;
      case ($urandom % 5)
        0: ins = {6'h00, 20'($urandom), 3'b110, 3'($urandom)};
        1: ins = {6'h01, 5'($urandom), 5'($urandom), 16'($urandom)};
        2: ins = {1'b0, 1'($urandom), 2'b01, 2'($urandom), 26'($urandom)};
        3: ins = mk_ri(5'($urandom), pick_val()  [15:0]);
        default: ins = $urandom;
      endcase
      a = pick_val();
      b = ($urandom % 4 == 0) ? a : pick_val();
      apply(ins, a, b, "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule